// File: doc/BRIEF.md
# Inter-Packet Start Spacing Controller

This block sits in a 64-bit packet stream between an upstream source and a downstream sink. Each packet names, on the user sideband of its final beat, how many clock cycles should separate its own first beat from the first beat of the packet after it. The block passes beats through unchanged, but it holds back the first beat of the next packet until that many cycles have gone by since the previous start. If the previous packet is still being sent at that point, or the sink refuses the beat when it is due, the next packet goes out as soon as it can.

An enable input decides whether new packets may begin. Packets that arrive while the enable is low wait at the input, and the first one leaves the moment the enable is raised. A sticky late flag records any case where a requested spacing could not be kept. Only a software-reset pulse or the hardware reset clears it.

The interval field is `IPT_W` bits wide and sits at bits `[IPT_W-1:0]` of the input user sideband. The field is only sampled on the beat that carries the last-beat marker.

Top module: `ipt_rate_ctrl`

## Requirements
- R1: Data, byte-enable and last-beat marker leave the output in the same order and with the same values as they entered. No beat is dropped, duplicated or altered.
- R2: While `active` is 0 and no packet is in progress, no beat is offered on the output. A packet that has already started finishes normally.
- R3: Assume the next packet is already waiting and `m_tready` is held at 1. Then the first beat of packet k+1 is transferred exactly max(I_k, L_k) cycles after the first beat of packet k. Here I_k is the `s_tuser[IPT_W-1:0]` value on the last beat of packet k, and L_k is its length in beats.
- R4: When I_k equals L_k, packets leave back to back with no idle cycle between them, and `late_flag` stays 0.
- R5: A last beat whose interval is shorter than the cycles the packet has taken sets `late_flag`. An interval of 0 counts as shorter. The flag is visible from the cycle after that beat.
- R6: A downstream stall also sets `late_flag`. This covers a stall that stretches a packet past its interval, and a stall that refuses a waiting first beat at or after its due cycle.
- R7: `late_flag` stays 1 until `sw_rst` is sampled high. It is 0 in the cycle after that, and `sw_rst` has priority over a simultaneous new lateness.
- R8: After hardware reset, `late_flag` is 0 and no output beat is offered while the input is idle.
- R9: The first packet after `active` rises leaves in the same cycle it is presented. No spacing is applied from packets sent before the block was disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous clear of the late flag |
| active | input | 1 | Allows new packets to start |
| s_tdata | input | DATA_W | Input beat data |
| s_tkeep | input | DATA_W/8 | Input byte enables |
| s_tuser | input | IPT_W | Interval in cycles, valid on last beat |
| s_tlast | input | 1 | Input last-beat marker |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| m_tdata | output | DATA_W | Output beat data |
| m_tkeep | output | DATA_W/8 | Output byte enables |
| m_tlast | output | 1 | Output last-beat marker |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| late_flag | output | 1 | Sticky spacing-violation flag (status bit 0) |

## Verification
The assertions run on every cycle and check the following:
- No packet starts before its interval has expired.
- The spacing counter restarts at each packet start.
- Nothing is offered while the block is disabled between packets.
- The late flag is sticky, and it is cleared by the software reset.
- The flag only rises after a detected lateness.

Some properties need whole scenarios from the bench. These are the exact start-to-start spacing, back-to-back delivery when the interval equals the length, intact data across packets of random length, and lateness under random downstream stalls.

// File: rtl/ipt_rate_pkg.sv
package ipt_rate_pkg;
   localparam int BYTE_BITS = 8;

   typedef enum logic {
      FR_GAP  = 1'b0,
      FR_BODY = 1'b1
   } frame_state_e;
endpackage

// File: rtl/ipt_frame_track.sv
module ipt_frame_track
   import ipt_rate_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic beat_xfer,
   input  logic beat_last,
   output logic in_body,
   output logic first_xfer,
   output logic last_xfer
);
   frame_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FR_GAP;
      end else if (beat_xfer) begin
         state_q <= beat_last ? FR_GAP : FR_BODY;
      end
   end

   assign in_body    = (state_q == FR_BODY);
   assign first_xfer = beat_xfer && (state_q == FR_GAP);
   assign last_xfer  = beat_xfer && beat_last;
endmodule

// File: rtl/ipt_gap_timer.sv
module ipt_gap_timer #(
   parameter int IPT_W = 28
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             first_xfer,
   input  logic             last_xfer,
   input  logic [IPT_W-1:0] last_ipt,
   input  logic             disarm,
   output logic             armed,
   output logic             reached,
   output logic             late_end
);
   localparam logic [IPT_W-1:0] CNT_MAX = '1;

   logic [IPT_W-1:0] cnt_q;
   logic [IPT_W-1:0] ipt_q;
   logic [IPT_W-1:0] cnt_inc;
   logic [IPT_W-1:0] cnt_next_start;

   generate
      if (IPT_W < 2) begin : g_bad_width
         $error("ipt_gap_timer: IPT_W must be at least 2");
      end
   endgenerate

   assign cnt_inc        = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
   assign cnt_next_start = first_xfer ? {{(IPT_W-1){1'b0}}, 1'b1} : cnt_inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ipt_q <= '0;
         armed <= 1'b0;
      end else begin
         cnt_q <= cnt_next_start;
         if (last_xfer) begin
            ipt_q <= last_ipt;
         end
         if (first_xfer) begin
            armed <= 1'b1;
         end else if (disarm) begin
            armed <= 1'b0;
         end
      end
   end

   assign reached  = armed && (cnt_q >= ipt_q);
   assign late_end = last_xfer && (cnt_next_start > last_ipt);

   a_r3_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
      (first_xfer && armed) |-> (cnt_q >= ipt_q));

   a_r3_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      first_xfer |=> (cnt_q == {{(IPT_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/ipt_late_flag.sv
module ipt_late_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_rst,
   input  logic set_late,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (sw_rst) begin
         flag <= 1'b0;
      end else if (set_late) begin
         flag <= 1'b1;
      end
   end

   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !sw_rst) |=> flag);

   a_r7_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> !flag);

   a_r5_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(set_late));
endmodule

// File: rtl/ipt_rate_ctrl.sv
module ipt_rate_ctrl
   import ipt_rate_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int IPT_W  = 28
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sw_rst,
   input  logic                          active,
   input  logic [DATA_W-1:0]             s_tdata,
   input  logic [DATA_W/BYTE_BITS-1:0]   s_tkeep,
   input  logic [IPT_W-1:0]              s_tuser,
   input  logic                          s_tlast,
   input  logic                          s_tvalid,
   output logic                          s_tready,
   output logic [DATA_W-1:0]             m_tdata,
   output logic [DATA_W/BYTE_BITS-1:0]   m_tkeep,
   output logic                          m_tlast,
   output logic                          m_tvalid,
   input  logic                          m_tready,
   output logic                          late_flag
);
   localparam int KEEP_W = DATA_W / BYTE_BITS;

   generate
      if (DATA_W % BYTE_BITS != 0) begin : g_bad_data_w
         $error("ipt_rate_ctrl: DATA_W must be a whole number of bytes");
      end
      if (KEEP_W < 1) begin : g_bad_keep_w
         $error("ipt_rate_ctrl: DATA_W too small");
      end
   endgenerate

   logic in_body;
   logic first_xfer;
   logic last_xfer;
   logic armed;
   logic reached;
   logic late_end;
   logic may_start;
   logic gate;
   logic beat_xfer;
   logic missed_start;

   assign may_start = active && (!armed || reached);
   assign gate      = in_body || may_start;
   assign m_tvalid  = s_tvalid && gate;
   assign s_tready  = m_tready && gate;
   assign beat_xfer = s_tvalid && s_tready;
   assign m_tdata   = s_tdata;
   assign m_tkeep   = s_tkeep;
   assign m_tlast   = s_tlast;

   assign missed_start = !in_body && active && reached && s_tvalid && !m_tready;

   ipt_frame_track u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_xfer  (beat_xfer),
      .beat_last  (s_tlast),
      .in_body    (in_body),
      .first_xfer (first_xfer),
      .last_xfer  (last_xfer)
   );

   ipt_gap_timer #(.IPT_W(IPT_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .first_xfer (first_xfer),
      .last_xfer  (last_xfer),
      .last_ipt   (s_tuser),
      .disarm     (!active && !in_body),
      .armed      (armed),
      .reached    (reached),
      .late_end   (late_end)
   );

   ipt_late_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_rst   (sw_rst),
      .set_late (late_end || missed_start),
      .flag     (late_flag)
   );

   a_r2_hold_inactive: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !in_body) |-> !m_tvalid);

   a_r1_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && m_tready) |-> (s_tvalid && s_tready));
endmodule

// File: tb/ipt_rate_ctrl_test.sv
module ipt_rate_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 64;
   localparam int IW = 28;
   localparam int MAXP = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_rst = 1'b0;
   logic active = 1'b0;
   logic [DW-1:0] s_tdata = '0;
   logic [DW/8-1:0] s_tkeep = '0;
   logic [IW-1:0] s_tuser = '0;
   logic s_tlast = 1'b0;
   logic s_tvalid = 1'b0;
   logic s_tready;
   logic [DW-1:0] m_tdata;
   logic [DW/8-1:0] m_tkeep;
   logic m_tlast;
   logic m_tvalid;
   logic m_tready = 1'b1;
   logic late_flag;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int pkt_len [MAXP];
   int pkt_ipt [MAXP];
   int start_cyc [MAXP];
   int rx_p = 0;
   int rx_b = 0;
   int mon_err = 0;
   bit bp_mode = 1'b0;
   int act_cyc = 0;

   ipt_rate_ctrl #(.DATA_W(DW), .IPT_W(IW)) uut (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .active(active),
      .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tuser(s_tuser),
      .s_tlast(s_tlast), .s_tvalid(s_tvalid), .s_tready(s_tready),
      .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
      .m_tvalid(m_tvalid), .m_tready(m_tready), .late_flag(late_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      #1;
      m_tready = bp_mode ? 1'($urandom % 2) : 1'b1;
   end

   function automatic logic [DW-1:0] exp_data(int p, int b);
      return {32'(p * 1000 + b), 32'hA500_0000 ^ 32'(b * 7)};
   endfunction

   function automatic logic [DW/8-1:0] exp_keep(int p, int b);
      return (b == pkt_len[p] - 1) ? (8'hFF >> (p % 8)) : 8'hFF;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R1 monitor: compares every output beat against the bench model
   always @(negedge clk) begin
      if (rst_n && m_tvalid && m_tready) begin
         if (m_tdata !== exp_data(rx_p, rx_b) || m_tkeep !== exp_keep(rx_p, rx_b) ||
             m_tlast !== (rx_b == pkt_len[rx_p] - 1))
            mon_err++;
         if (rx_b == 0) start_cyc[rx_p] = cyc;
         if (m_tlast) begin
            rx_p++;
            rx_b = 0;
         end else begin
            rx_b++;
         end
      end
   end

   task automatic src_send(int n);
      for (int p = 0; p < n; p++) begin
         for (int b = 0; b < pkt_len[p]; b++) begin
            bit hs;
            s_tvalid = 1'b1;
            s_tdata  = exp_data(p, b);
            s_tkeep  = exp_keep(p, b);
            s_tlast  = (b == pkt_len[p] - 1);
            s_tuser  = (b == pkt_len[p] - 1) ? IW'(pkt_ipt[p]) : '0;
            do begin
               @(negedge clk);
               hs = s_tvalid && s_tready;
               @(posedge clk);
               #1;
            end while (!hs);
         end
      end
      s_tvalid = 1'b0;
      s_tlast  = 1'b0;
   endtask

   task automatic run_set(int n, bit bp, bit chk_gaps, string tag);
      int guard;
      rx_p = 0;
      rx_b = 0;
      mon_err = 0;
      active = 1'b0;
      fork
         src_send(n);
      join_none
      repeat (20) begin
         @(posedge clk);
         #1;
      end
      check(rx_p == 0 && rx_b == 0, "R2 no output while inactive", rx_p * 1000 + rx_b, 0);
      bp_mode = bp;
      active = 1'b1;
      act_cyc = cyc;
      guard = 0;
      while (rx_p < n && guard < 30000) begin
         @(posedge clk);
         #1;
         guard++;
      end
      check(rx_p == n, {"R1 all packets delivered ", tag}, rx_p, n);
      check(mon_err == 0, {"R1 beat content ", tag}, mon_err, 0);
      if (!bp) check(start_cyc[0] == act_cyc, {"R9 first start on enable ", tag},
                     start_cyc[0] - act_cyc, 0);
      if (chk_gaps) begin
         for (int k = 0; k + 1 < n; k++) begin
            int e = (pkt_ipt[k] > pkt_len[k]) ? pkt_ipt[k] : pkt_len[k];
            check(start_cyc[k+1] - start_cyc[k] == e, {"R3 start spacing ", tag},
                  start_cyc[k+1] - start_cyc[k], e);
         end
      end
      repeat (3) begin
         @(posedge clk);
         #1;
      end
      active = 1'b0;
      bp_mode = 1'b0;
   endtask

   task automatic pulse_sw_rst();
      sw_rst = 1'b1;
      @(posedge clk);
      #1;
      sw_rst = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      check(late_flag == 1'b0, "R8 flag after reset", late_flag, 0);
      check(m_tvalid == 1'b0, "R8 output idle after reset", m_tvalid, 0);

      // random lengths, intervals never shorter than length
      for (int p = 0; p < 20; p++) begin
         pkt_len[p] = 1 + int'($urandom % 12);
         pkt_ipt[p] = pkt_len[p] + ((p % 4 == 0) ? 0 : int'($urandom % 11));
      end
      run_set(20, 1'b0, 1'b1, "random");
      check(late_flag == 1'b0, "R3 no flag when intervals met", late_flag, 0);

      // back to back: 800-byte packets, interval equal to length
      for (int p = 0; p < 4; p++) begin
         pkt_len[p] = 100;
         pkt_ipt[p] = 100;
      end
      run_set(4, 1'b0, 1'b1, "b2b");
      check(late_flag == 1'b0, "R4 back to back no flag", late_flag, 0);

      // one cycle short
      for (int p = 0; p < 4; p++) pkt_ipt[p] = 99;
      run_set(4, 1'b0, 1'b1, "short");
      check(late_flag == 1'b1, "R5 short interval flags", late_flag, 1);

      repeat (30) @(posedge clk);
      @(negedge clk);
      check(late_flag == 1'b1, "R7 flag remains set", late_flag, 1);
      pulse_sw_rst();
      check(late_flag == 1'b0, "R7 software reset clears", late_flag, 0);

      // single-beat packets with zero interval
      for (int p = 0; p < 3; p++) begin
         pkt_len[p] = 1;
         pkt_ipt[p] = 0;
      end
      run_set(3, 1'b0, 1'b1, "zero");
      check(late_flag == 1'b1, "R5 zero interval flags", late_flag, 1);
      pulse_sw_rst();
      check(late_flag == 1'b0, "R7 clear after zero case", late_flag, 0);

      // downstream stalls with exact intervals
      for (int p = 0; p < 4; p++) begin
         pkt_len[p] = 100;
         pkt_ipt[p] = 100;
      end
      run_set(4, 1'b1, 1'b0, "stall");
      check(late_flag == 1'b1, "R6 backpressure flags", late_flag, 1);
      pulse_sw_rst();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule